// File: doc/BRIEF.md
# MSI Event Queue Dispatcher

This block receives message-signalled interrupt writes and records each one as a two-word entry in one of several circular event queues. The queues are held in system memory. A per-MSI steering table picks the destination queue for each MSI number. Each entry in that table carries a valid flag and a pending lock. Once an MSI has posted, it cannot post again until software releases the lock.

Each queue keeps a 7-bit head pointer, a 7-bit tail pointer, an enable, an overflow flag and a derived one-hot state. Software drains a queue by advancing its head. Entries leave the block through a memory-write request port with a valid/ready handshake. Configuration uses a flat register port with a 12-bit address. Bits 11:8 select a register group and bits 7:0 select the MSI or queue index. The groups are:

| Group | Register |
|-------|----------|
| 0 | steering entry |
| 1 | pending release |
| 2 | control set |
| 3 | control clear |
| 4 | state, read-only |
| 5 | tail |
| 6 | head |
| 7 | queue memory base |

Reads are combinational from `reg_addr`.

Top module: `msiq_dispatch`

## Requirements
- R1: After reset, every queue has head = 0, tail = 0, overflow clear, enable clear and state 1 (idle). Every steering entry reads 0, `mw_valid` is low and `msi_ready` is high.
- R2: A steering entry is written and read with the valid flag in bit 63 and the destination queue in bits 5:0. Bit 62 reads the pending lock, and writes to the steering register do not change that lock. An MSI whose entry is not valid is accepted and dropped: no memory write happens and no tail moves.
- R3: A posted MSI issues two beats. The first beat goes to base + queue×8192 + tail×64 and the second to that address + 8. `msi_ready` stays low until the second beat is accepted, and then the queue's tail advances by one.
- R4: Word 0 has bit 63 = 0 and a format field in bits 62:56 equal to 0x58 for a 32-bit-address MSI or 0x78 for a 64-bit one. It also has length 1 in bits 55:46, msi_addr[15:2] in bits 45:32, the requester ID in bits 31:16 and msi_data[15:0] in bits 15:0. Word 1 has msi_addr[63:16] in bits 63:16 (upper 32 bits forced to 0 for a 32-bit MSI) and msi_data[31:16] in bits 15:0.
- R5: After a post, the MSI's pending lock (bit 62 of its steering entry) is set, and further MSIs with that number are dropped. Writing a 1 to bit 62 of the MSI's pending-release register clears the lock.
- R6: Writing bit 44 to a queue's control-set register enables the queue, and writing bit 44 to its control-clear register disables it. Both registers read the enable at bit 44. An MSI steered to a disabled queue is dropped.
- R7: If advancing the tail would make it equal to the head, nothing is written, the tail holds, the overflow flag is set and the state becomes 4 (error). The tail register shows the flag at bit 57. Writing bit 57 to control-clear clears the flag, and writing bit 57 to control-set sets it.
- R8: With overflow clear, the state reads 2 (active) while head ≠ tail and 1 (idle) when they are equal. Writing the head register drains the queue.
- R9: Head and tail are 7-bit pointers that software can write. An entry posted at tail 127 lands at slot 127, and the tail then wraps to 0.
- R10: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold steady.
- R11: An MSI steered to a queue number not below NUM_EQ is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Incoming MSI present |
| msi_ready | output | 1 | Dispatcher can take an MSI |
| msi_num | input | MSI_W | MSI number |
| msi_is64 | input | 1 | MSI used a 64-bit address |
| msi_rid | input | 16 | Requester ID |
| msi_addr | input | 64 | MSI target address |
| msi_data | input | 32 | MSI payload |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register group (11:8) and index (7:0) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory write beat accepted |
| mw_addr | output | 64 | Memory write byte address |
| mw_data | output | 64 | Memory write data |

## Verification
The bench builds the block with NUM_MSI = 8 and NUM_EQ = 4. This keeps every queue number from 0 to 3 reachable, and it still leaves steering values 4 to 63 available to exercise the out-of-range drop. Because head and tail can be written, the overflow and wrap corners are reached by presetting the pointers rather than by filling 127 slots. A stalling `mw_ready` pattern drives the beat-hold rule.

// File: rtl/msiq_pkg.sv
package msiq_pkg;

  localparam int PTR_W  = 7;
  localparam int REG_AW = 12;

  localparam int B_VALID = 63;
  localparam int B_PEND  = 62;
  localparam int B_OVF   = 57;
  localparam int B_EN    = 44;

  localparam logic [2:0] ST_IDLE = 3'b001;
  localparam logic [2:0] ST_ACT  = 3'b010;
  localparam logic [2:0] ST_ERR  = 3'b100;

  typedef struct packed {
    logic       valid;
    logic       pend;
    logic [5:0] eq;
  } map_ent_t;

  typedef enum logic [3:0] {
    RG_MAP   = 4'd0,
    RG_PCLR  = 4'd1,
    RG_CSET  = 4'd2,
    RG_CCLR  = 4'd3,
    RG_STATE = 4'd4,
    RG_TAIL  = 4'd5,
    RG_HEAD  = 4'd6,
    RG_BASE  = 4'd7
  } reg_region_e;

  typedef enum logic [1:0] {PS_IDLE, PS_W0, PS_W1} post_st_e;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [63:0] entry_addr(input logic [63:0] base,
                                             input logic [5:0] q,
                                             input logic [PTR_W-1:0] t);
    return base + (64'(q) << 13) + (64'(t) << 6);
  endfunction

  function automatic logic [6:0] fmt_of(input logic is64);
    return is64 ? 7'h78 : 7'h58;
  endfunction

  function automatic logic [63:0] pack_w0(input logic is64, input logic [15:0] rid,
                                          input logic [63:0] addr, input logic [31:0] data);
    return {1'b0, fmt_of(is64), 10'd1, addr[15:2], rid, data[15:0]};
  endfunction

  function automatic logic [63:0] pack_w1(input logic is64, input logic [63:0] addr,
                                          input logic [31:0] data);
    logic [47:0] up;
    up = is64 ? addr[63:16] : {32'b0, addr[31:16]};
    return {up, data[31:16]};
  endfunction

  function automatic logic [2:0] queue_state(input logic ovf, input logic [PTR_W-1:0] hd,
                                             input logic [PTR_W-1:0] tl);
    if (ovf) return ST_ERR;
    if (hd != tl) return ST_ACT;
    return ST_IDLE;
  endfunction

endpackage

// File: rtl/msiq_map_table.sv
module msiq_map_table
  import msiq_pkg::*;
#(
  parameter int NUM_MSI = 32,
  parameter int MSI_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             clr_en,
  input  logic [MSI_W-1:0] wr_idx,
  input  logic [63:0]      wdata,
  input  logic             set_pend,
  input  logic [MSI_W-1:0] set_idx,
  input  logic [MSI_W-1:0] lk_idx,
  output map_ent_t         lk_ent,
  input  logic [MSI_W-1:0] rd_idx,
  output map_ent_t         rd_ent
);

  map_ent_t ents [NUM_MSI];

  for (genvar i = 0; i < NUM_MSI; i++) begin : g_ent
    map_ent_t ent_q;
    logic     sel_w;
    logic     sel_p;
    assign sel_w = (wr_idx == MSI_W'(i));
    assign sel_p = set_pend && (set_idx == MSI_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else begin
        if (wr_en && sel_w) begin
          ent_q.valid <= wdata[B_VALID];
          ent_q.eq    <= wdata[5:0];
        end
        if (sel_p)
          ent_q.pend <= 1'b1;
        else if (clr_en && sel_w && wdata[B_PEND])
          ent_q.pend <= 1'b0;
      end
    end
    assign ents[i] = ent_q;
  end

  assign lk_ent = ents[lk_idx];
  assign rd_ent = ents[rd_idx];

endmodule

// File: rtl/msiq_queue_bank.sv
module msiq_queue_bank
  import msiq_pkg::*;
#(
  parameter int NUM_EQ = 36,
  parameter int EQ_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cset,
  input  logic             cclr,
  input  logic             head_wr,
  input  logic             tail_wr,
  input  logic [EQ_W-1:0]  wr_idx,
  input  logic [63:0]      wdata,
  input  logic             adv,
  input  logic [EQ_W-1:0]  adv_idx,
  input  logic             ovf_hit,
  input  logic [EQ_W-1:0]  ovf_idx,
  input  logic [EQ_W-1:0]  lk_idx,
  output logic             lk_en,
  output logic             lk_full,
  output logic [PTR_W-1:0] lk_tail,
  input  logic [EQ_W-1:0]  rd_idx,
  output logic             rd_en,
  output logic             rd_ovf,
  output logic [PTR_W-1:0] rd_head,
  output logic [PTR_W-1:0] rd_tail
);

  logic             en_a   [NUM_EQ];
  logic             ovf_a  [NUM_EQ];
  logic [PTR_W-1:0] head_a [NUM_EQ];
  logic [PTR_W-1:0] tail_a [NUM_EQ];

  for (genvar i = 0; i < NUM_EQ; i++) begin : g_q
    logic             en_q, ovf_q;
    logic [PTR_W-1:0] head_q, tail_q;
    logic             sel;
    assign sel = (wr_idx == EQ_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        ovf_q  <= 1'b0;
        head_q <= '0;
        tail_q <= '0;
      end else begin
        if (cset && sel && wdata[B_EN])      en_q <= 1'b1;
        else if (cclr && sel && wdata[B_EN]) en_q <= 1'b0;

        if ((ovf_hit && ovf_idx == EQ_W'(i)) || (cset && sel && wdata[B_OVF]))
          ovf_q <= 1'b1;
        else if (cclr && sel && wdata[B_OVF])
          ovf_q <= 1'b0;

        if (head_wr && sel) head_q <= wdata[PTR_W-1:0];

        if (tail_wr && sel)                     tail_q <= wdata[PTR_W-1:0];
        else if (adv && adv_idx == EQ_W'(i))    tail_q <= next_ptr(tail_q);
      end
    end

    assign en_a[i]   = en_q;
    assign ovf_a[i]  = ovf_q;
    assign head_a[i] = head_q;
    assign tail_a[i] = tail_q;
  end

  assign lk_en   = en_a[lk_idx];
  assign lk_tail = tail_a[lk_idx];
  assign lk_full = (next_ptr(tail_a[lk_idx]) == head_a[lk_idx]);

  assign rd_en   = en_a[rd_idx];
  assign rd_ovf  = ovf_a[rd_idx];
  assign rd_head = head_a[rd_idx];
  assign rd_tail = tail_a[rd_idx];

endmodule

// File: rtl/msiq_dispatch.sv
module msiq_dispatch
  import msiq_pkg::*;
#(
  parameter int NUM_MSI = 32,
  parameter int NUM_EQ  = 36,
  localparam int MSI_W  = (NUM_MSI > 1) ? $clog2(NUM_MSI) : 1,
  localparam int EQ_W   = (NUM_EQ > 1) ? $clog2(NUM_EQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_valid,
  output logic              msi_ready,
  input  logic [MSI_W-1:0]  msi_num,
  input  logic              msi_is64,
  input  logic [15:0]       msi_rid,
  input  logic [63:0]       msi_addr,
  input  logic [31:0]       msi_data,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [63:0]       mw_addr,
  output logic [63:0]       mw_data
);

  reg_region_e region;
  logic [7:0]  ridx;
  logic        msi_hit, eq_hit;
  assign region  = reg_region_e'(reg_addr[11:8]);
  assign ridx    = reg_addr[7:0];
  assign msi_hit = int'(ridx) < NUM_MSI;
  assign eq_hit  = int'(ridx) < NUM_EQ;

  logic wr_map, wr_pclr, wr_cset, wr_cclr, wr_tail, wr_head, wr_base;
  assign wr_map  = reg_wr && region == RG_MAP  && msi_hit;
  assign wr_pclr = reg_wr && region == RG_PCLR && msi_hit;
  assign wr_cset = reg_wr && region == RG_CSET && eq_hit;
  assign wr_cclr = reg_wr && region == RG_CCLR && eq_hit;
  assign wr_tail = reg_wr && region == RG_TAIL && eq_hit;
  assign wr_head = reg_wr && region == RG_HEAD && eq_hit;
  assign wr_base = reg_wr && region == RG_BASE;

  logic [63:0] base_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (wr_base) base_q <= {reg_wdata[63:6], 6'b0};
  end

  // Posting state
  post_st_e         st_q;
  logic [EQ_W-1:0]  cur_q;
  logic [MSI_W-1:0] cur_num;
  logic [63:0]      cur_addr, cur_w0, cur_w1;

  // Named internal events
  logic ev_accept, ev_eligible, ev_post, ev_ovf, ev_drop, ev_done, beat_w0;

  map_ent_t         lk_ent, rd_ent;
  logic             lk_en, lk_full;
  logic [PTR_W-1:0] lk_tail;
  logic             rd_en, rd_ovf;
  logic [PTR_W-1:0] rd_head, rd_tail;
  logic             num_ok, q_ok;

  assign msi_ready   = (st_q == PS_IDLE);
  assign ev_accept   = msi_valid && msi_ready;
  assign num_ok      = int'(msi_num) < NUM_MSI;
  assign q_ok        = int'(lk_ent.eq) < NUM_EQ;
  assign ev_eligible = ev_accept && num_ok && lk_ent.valid && !lk_ent.pend && q_ok && lk_en;
  assign ev_ovf      = ev_eligible && lk_full;
  assign ev_post     = ev_eligible && !lk_full;
  assign ev_drop     = ev_accept && !ev_post;
  assign ev_done     = (st_q == PS_W1) && mw_ready;
  assign beat_w0     = (st_q == PS_W0);

  msiq_map_table #(.NUM_MSI(NUM_MSI), .MSI_W(MSI_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_map),
    .clr_en   (wr_pclr),
    .wr_idx   (ridx[MSI_W-1:0]),
    .wdata    (reg_wdata),
    .set_pend (ev_done),
    .set_idx  (cur_num),
    .lk_idx   (msi_num),
    .lk_ent   (lk_ent),
    .rd_idx   (ridx[MSI_W-1:0]),
    .rd_ent   (rd_ent)
  );

  msiq_queue_bank #(.NUM_EQ(NUM_EQ), .EQ_W(EQ_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .cset    (wr_cset),
    .cclr    (wr_cclr),
    .head_wr (wr_head),
    .tail_wr (wr_tail),
    .wr_idx  (ridx[EQ_W-1:0]),
    .wdata   (reg_wdata),
    .adv     (ev_done),
    .adv_idx (cur_q),
    .ovf_hit (ev_ovf),
    .ovf_idx (lk_ent.eq[EQ_W-1:0]),
    .lk_idx  (lk_ent.eq[EQ_W-1:0]),
    .lk_en   (lk_en),
    .lk_full (lk_full),
    .lk_tail (lk_tail),
    .rd_idx  (ridx[EQ_W-1:0]),
    .rd_en   (rd_en),
    .rd_ovf  (rd_ovf),
    .rd_head (rd_head),
    .rd_tail (rd_tail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= PS_IDLE;
      cur_q    <= '0;
      cur_num  <= '0;
      cur_addr <= '0;
      cur_w0   <= '0;
      cur_w1   <= '0;
    end else begin
      case (st_q)
        PS_IDLE: if (ev_post) begin
          st_q     <= PS_W0;
          cur_q    <= lk_ent.eq[EQ_W-1:0];
          cur_num  <= msi_num;
          cur_addr <= entry_addr(base_q, lk_ent.eq, lk_tail);
          cur_w0   <= pack_w0(msi_is64, msi_rid, msi_addr, msi_data);
          cur_w1   <= pack_w1(msi_is64, msi_addr, msi_data);
        end
        PS_W0:   if (mw_ready) st_q <= PS_W1;
        PS_W1:   if (mw_ready) st_q <= PS_IDLE;
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  assign mw_valid = (st_q == PS_W0) || (st_q == PS_W1);
  assign mw_addr  = beat_w0 ? cur_addr : cur_addr + 64'd8;
  assign mw_data  = beat_w0 ? cur_w0 : cur_w1;

  always_comb begin
    reg_rdata = '0;
    case (region)
      RG_MAP:   if (msi_hit) begin
        reg_rdata[B_VALID] = rd_ent.valid;
        reg_rdata[B_PEND]  = rd_ent.pend;
        reg_rdata[5:0]     = rd_ent.eq;
      end
      RG_CSET, RG_CCLR: if (eq_hit) begin
        reg_rdata[B_EN]  = rd_en;
        reg_rdata[B_OVF] = rd_ovf;
      end
      RG_STATE: if (eq_hit) reg_rdata[2:0] = queue_state(rd_ovf, rd_head, rd_tail);
      RG_TAIL:  if (eq_hit) begin
        reg_rdata[B_OVF]       = rd_ovf;
        reg_rdata[PTR_W-1:0]   = rd_tail;
      end
      RG_HEAD:  if (eq_hit) reg_rdata[PTR_W-1:0] = rd_head;
      RG_BASE:  reg_rdata = base_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/msiq_dispatch_chk.sv
module msiq_dispatch_chk #(
  parameter int NUM_EQ = 36
) (
  input logic        clk,
  input logic        rst_n,
  input logic        msi_ready,
  input logic        mw_valid,
  input logic        mw_ready,
  input logic [63:0] mw_addr,
  input logic [63:0] mw_data,
  input logic [11:0] reg_addr,
  input logic [63:0] reg_rdata,
  input logic        ev_ovf,
  input logic        ev_post,
  input logic        beat_w0
);

  p_beat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> !msi_ready);

  p_post_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_post |=> mw_valid && beat_w0);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> !mw_valid);

  p_word0_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && beat_w0 |-> !mw_data[63] &&
      (mw_data[62:56] == 7'h58 || mw_data[62:56] == 7'h78));

  p_state_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[11:8] == 4'd4 && int'(reg_addr[7:0]) < NUM_EQ) |-> $countones(reg_rdata[2:0]) == 1);

endmodule

bind msiq_dispatch msiq_dispatch_chk #(.NUM_EQ(NUM_EQ)) u_chk (.*);

// File: tb/msiq_dispatch_test.sv
module msiq_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NMSI = 8;
  localparam int NEQ  = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        msi_valid = 0;
  logic        msi_ready;
  logic [2:0]  msi_num = 0;
  logic        msi_is64 = 0;
  logic [15:0] msi_rid = 0;
  logic [63:0] msi_addr = 0;
  logic [31:0] msi_data = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic        mw_valid;
  logic        mw_ready = 1;
  logic [63:0] mw_addr, mw_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit stall   = 0;
  int cap_n   = 0;
  logic [63:0] cap_addr [64];
  logic [63:0] cap_data [64];

  localparam logic [63:0] BASE = 64'h0000_0001_0000_0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  msiq_dispatch #(.NUM_MSI(NMSI), .NUM_EQ(NEQ)) uut (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_num(msi_num), .msi_is64(msi_is64), .msi_rid(msi_rid), .msi_addr(msi_addr),
    .msi_data(msi_data), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_data(mw_data));

  always @(posedge clk) begin
    #2;
    mw_ready <= stall ? ~mw_ready : 1'b1;
  end

  always @(negedge clk) begin
    if (mw_valid && mw_ready && cap_n < 64) begin
      cap_addr[cap_n] = mw_addr;
      cap_data[cap_n] = mw_data;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] ra(input int grp, input int idx);
    return {4'(grp), 8'(idx)};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input int num, input bit is64, input logic [15:0] rid,
                      input logic [63:0] addr, input logic [31:0] data);
    @(negedge clk);
    msi_num = 3'(num); msi_is64 = is64; msi_rid = rid; msi_addr = addr; msi_data = data;
    msi_valid = 1;
    @(negedge clk);
    msi_valid = 0;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_w0(input bit is64, input logic [15:0] rid,
                                         input logic [63:0] addr, input logic [31:0] data);
    logic [63:0] f;
    f = is64 ? 64'h78 : 64'h58;
    return (f << 56) | (64'd1 << 46) | (((addr >> 2) & 64'h3fff) << 32) |
           (64'(rid) << 16) | 64'(data & 32'hffff);
  endfunction

  function automatic logic [63:0] exp_w1(input bit is64, input logic [63:0] addr,
                                         input logic [31:0] data);
    logic [63:0] a;
    a = is64 ? addr : (addr & 64'hffff_ffff);
    return ((a >> 16) << 16) | 64'(data >> 16);
  endfunction

  task automatic t_reset;
    logic [63:0] v;
    chk(mw_valid == 0, "R1", "mw_valid", 64'(mw_valid), 0);
    chk(msi_ready == 1, "R1", "msi_ready", 64'(msi_ready), 1);
    for (int q = 0; q < NEQ; q++) begin
      rd(ra(4, q), v); chk(v == 1, "R1", "state idle", v, 1);
      rd(ra(5, q), v); chk(v == 0, "R1", "tail", v, 0);
      rd(ra(6, q), v); chk(v == 0, "R1", "head", v, 0);
      rd(ra(2, q), v); chk(v == 0, "R1", "ctl", v, 0);
    end
    rd(ra(0, 3), v); chk(v == 0, "R1", "map", v, 0);
  endtask

  task automatic t_map_rw;
    logic [63:0] v;
    wr(ra(0, 3), 64'hC000_0000_0000_0002);
    rd(ra(0, 3), v);
    chk(v == 64'h8000_0000_0000_0002, "R2", "map readback, lock untouched", v, 64'h8000_0000_0000_0002);
  endtask

  task automatic t_basic_post;
    logic [63:0] v, ea;
    int s;
    wr(ra(7, 0), BASE);
    wr(ra(2, 2), 64'd1 << 44);
    s = cap_n;
    send(3, 0, 16'h1234, 64'h0000_0000_FEE0_1230, 32'hABCD_0003);
    ea = BASE + 2 * 8192;
    chk(cap_n - s == 2, "R3", "beat count", 64'(cap_n - s), 2);
    chk(cap_addr[s] == ea, "R3", "beat0 addr", cap_addr[s], ea);
    chk(cap_addr[s+1] == ea + 8, "R3", "beat1 addr", cap_addr[s+1], ea + 8);
    chk(cap_data[s] == exp_w0(0, 16'h1234, 64'hFEE0_1230, 32'hABCD_0003), "R4", "word0 32b",
        cap_data[s], exp_w0(0, 16'h1234, 64'hFEE0_1230, 32'hABCD_0003));
    chk(cap_data[s+1] == exp_w1(0, 64'hFEE0_1230, 32'hABCD_0003), "R4", "word1 32b",
        cap_data[s+1], exp_w1(0, 64'hFEE0_1230, 32'hABCD_0003));
    rd(ra(5, 2), v); chk(v == 1, "R3", "tail advanced", v, 1);
    rd(ra(4, 2), v); chk(v == 2, "R8", "state active", v, 2);
    wr(ra(6, 2), 1);
    rd(ra(4, 2), v); chk(v == 1, "R8", "state idle after head write", v, 1);
  endtask

  task automatic t_stall_64;
    logic [63:0] v, ea, ad;
    int s;
    ad = 64'h0000_1234_5678_9ABC;
    wr(ra(0, 5), (64'd1 << 63) | 64'd1);
    wr(ra(2, 1), 64'd1 << 44);
    stall = 1;
    s = cap_n;
    send(5, 1, 16'hBEEF, ad, 32'h5555_0005);
    stall = 0;
    ea = BASE + 8192;
    chk(cap_n - s == 2, "R10", "beats under stall", 64'(cap_n - s), 2);
    chk(cap_addr[s] == ea, "R10", "beat0 addr stall", cap_addr[s], ea);
    chk(cap_data[s] == exp_w0(1, 16'hBEEF, ad, 32'h5555_0005), "R4", "word0 64b",
        cap_data[s], exp_w0(1, 16'hBEEF, ad, 32'h5555_0005));
    chk(cap_data[s+1] == exp_w1(1, ad, 32'h5555_0005), "R4", "word1 64b",
        cap_data[s+1], exp_w1(1, ad, 32'h5555_0005));
    rd(ra(5, 1), v); chk(v == 1, "R3", "tail q1", v, 1);
  endtask

  task automatic t_pending;
    logic [63:0] v;
    int s;
    rd(ra(0, 3), v); chk(v[62] == 1, "R5", "lock set after post", v, 64'h1);
    s = cap_n;
    send(3, 0, 16'h1, 64'hFEE0_0000, 32'h3);
    chk(cap_n == s, "R5", "locked MSI dropped", 64'(cap_n - s), 0);
    rd(ra(5, 2), v); chk(v == 1, "R5", "tail unchanged", v, 1);
    wr(ra(1, 3), 64'd1 << 62);
    rd(ra(0, 3), v); chk(v[62] == 0, "R5", "lock released", v, 0);
    send(3, 0, 16'h1, 64'hFEE0_0000, 32'h3);
    chk(cap_n - s == 2, "R5", "posts after release", 64'(cap_n - s), 2);
    rd(ra(5, 2), v); chk(v == 2, "R5", "tail after release", v, 2);
    wr(ra(1, 3), 64'd1 << 62);
  endtask

  task automatic t_drops;
    logic [63:0] v;
    int s;
    s = cap_n;
    send(6, 0, 16'h2, 64'hFEE0_0000, 32'h6);
    chk(cap_n == s, "R2", "invalid MSI dropped", 64'(cap_n - s), 0);
    wr(ra(0, 4), (64'd1 << 63) | 64'd9);
    send(4, 0, 16'h2, 64'hFEE0_0000, 32'h4);
    chk(cap_n == s, "R11", "queue out of range dropped", 64'(cap_n - s), 0);
    rd(ra(0, 4), v); chk(v[62] == 0, "R11", "no lock on drop", v, 0);
  endtask

  task automatic t_disable;
    logic [63:0] v;
    int s;
    wr(ra(3, 2), 64'd1 << 44);
    rd(ra(2, 2), v); chk(v[44] == 0, "R6", "enable cleared", v, 0);
    s = cap_n;
    send(3, 0, 16'h3, 64'hFEE0_0000, 32'h3);
    chk(cap_n == s, "R6", "disabled queue drops", 64'(cap_n - s), 0);
    rd(ra(5, 2), v); chk(v == 2, "R6", "tail held", v, 2);
    wr(ra(2, 2), 64'd1 << 44);
    rd(ra(3, 2), v); chk(v[44] == 1, "R6", "enable set", v, 64'd1 << 44);
  endtask

  task automatic t_overflow;
    logic [63:0] v;
    int s;
    wr(ra(2, 0), 64'd1 << 44);
    wr(ra(5, 0), 4);
    wr(ra(6, 0), 5);
    wr(ra(0, 1), (64'd1 << 63) | 64'd0);
    s = cap_n;
    send(1, 0, 16'h7, 64'hFEE0_0000, 32'h1);
    chk(cap_n == s, "R7", "full queue not written", 64'(cap_n - s), 0);
    rd(ra(5, 0), v);
    chk(v == ((64'd1 << 57) | 4), "R7", "tail with ovf flag", v, (64'd1 << 57) | 4);
    rd(ra(4, 0), v); chk(v == 4, "R7", "state error", v, 4);
    wr(ra(3, 0), 64'd1 << 57);
    rd(ra(4, 0), v); chk(v == 2, "R7", "state after ovf clear", v, 2);
    wr(ra(2, 0), 64'd1 << 57);
    rd(ra(4, 0), v); chk(v == 4, "R7", "ovf set by software", v, 4);
    wr(ra(3, 0), 64'd1 << 57);
  endtask

  task automatic t_wrap;
    logic [63:0] v, ea;
    int s;
    wr(ra(2, 3), 64'd1 << 44);
    wr(ra(5, 3), 127);
    wr(ra(6, 3), 127);
    wr(ra(0, 7), (64'd1 << 63) | 64'd3);
    s = cap_n;
    send(7, 0, 16'h9, 64'hFEE0_0000, 32'h7);
    ea = BASE + 3 * 8192 + 127 * 64;
    chk(cap_n - s == 2, "R9", "post at slot 127", 64'(cap_n - s), 2);
    chk(cap_addr[s] == ea, "R9", "slot 127 addr", cap_addr[s], ea);
    rd(ra(5, 3), v); chk(v == 0, "R9", "tail wrapped", v, 0);
    rd(ra(4, 3), v); chk(v == 2, "R8", "active after wrap", v, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_map_rw();
    t_basic_post();
    t_stall_64();
    t_pending();
    t_drops();
    t_disable();
    t_overflow();
    t_wrap();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule